// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside the bit engine of an I2C master and watches the shared two-wire bus. It follows START and STOP conditions so the local master knows whether the bus is owned by anyone. While the local master drives SDA, the monitor compares the level it means to put on the wire with the level actually seen there. The comparison is made only while SCL is high. If the local master intends a 1 but the wire reads 0, another master has won. When that happens the monitor tells the local engine to release SDA and to stop producing SCL until the bus is free again.

The comparison is active in the address phase, in the high-speed master-code phase and in the data phase. Two masters that address the same slave can therefore still be separated while data is sent. In high-speed mode the contest always ends within the unique master code. There is no priority between masters, and slaves take no part in the contest. The lost flag stays set after the bus is free, and software must clear it before the local master may start again. Line samples are expected to be synchronised already. Clock stretching, clock synchronisation between masters and slave behaviour are handled elsewhere.

The bus tracker has two states, BUS_IDLE and BUS_BUSY. A detected START moves it from BUS_IDLE to BUS_BUSY, and a detected STOP moves it back. If both are seen in one cycle, START wins. The arbitration tracker has three states. ARB_WATCH goes to ARB_LOST_BUSY on a qualified mismatch. ARB_LOST_BUSY goes to ARB_LOST_DONE on a detected STOP. ARB_LOST_DONE goes back to ARB_WATCH on a software clear.

Top module: `i2c_arb_monitor`

## Requirements
- R1: A START (SDA sampled 1 then 0 while SCL is sampled 1 on both samples), from any master, makes `bus_busy` 1 after the next clock edge.
- R2: A STOP (SDA sampled 0 then 1 while SCL is sampled 1 on both samples) makes `bus_busy` 0 after the next clock edge, unless a START is detected in the same cycle.
- R3: A mismatch is `drive_en`=1, `sda_intent`=1, `scl_in`=1 and `sda_in`=0, with `ack_slot`=0 and `phase`≠2'b11. A mismatch while not lost sets `arb_lost`, `sda_off` and `scl_off` to 1 after the next edge.
- R4: There is no loss while `scl_in` is 0, while `sda_intent` is 0, or while `drive_en` is 0, even when SDA reads 0.
- R5: A mismatch has no effect while `ack_slot` is 1, or while `phase` is 2'b11 (no arbitrated phase).
- R6: A loss is detected in the address phase (`phase`=2'b00), the high-speed master-code phase (2'b01) and the data phase (2'b10). `lost_phase` holds the phase code that was present at the loss.
- R7: `sda_off` and `scl_off` stay 1 until a STOP is detected and are 0 after the edge that sees it; `arb_lost` stays 1 through that STOP.
- R8: `arb_lost` is sticky. `lost_clr` has no effect while the releases are active. After the STOP, `lost_clr` returns `arb_lost` to 0 and `lost_phase` to 2'b00 after the next edge.
- R9: `start_ok` is 1 only when `bus_busy` is 0 and `arb_lost` is 0.
- R10: After reset, `bus_busy`, `arb_lost`, `sda_off` and `scl_off` are 0, `start_ok` is 1 and `lost_phase` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sda_in | input | 1 | Synchronised SDA sample |
| scl_in | input | 1 | Synchronised SCL sample |
| sda_intent | input | 1 | Level the local master means to put on SDA |
| drive_en | input | 1 | Local master is driving SDA for the current bit |
| ack_slot | input | 1 | Current bit is the acknowledge bit |
| phase | input | 2 | 00 address, 01 high-speed code, 10 data, 11 none |
| lost_clr | input | 1 | Software clear of the lost flag |
| bus_busy | output | 1 | Bus owned between START and STOP |
| arb_lost | output | 1 | Sticky lost-arbitration flag |
| sda_off | output | 1 | Release SDA output stage |
| scl_off | output | 1 | Stop generating SCL |
| start_ok | output | 1 | Local master may begin a transfer |
| lost_phase | output | 2 | Phase code recorded at the loss |

## Verification
The bench targets mismatches that must not count: SCL low, an intended 0, not driving, the acknowledge bit and the no-phase code. A design that compares without these qualifiers would drop out of transfers it should win. It also sends a software clear while SDA and SCL are still released, and continues past the STOP to check that the flag persists. A design that let either action end the loss early would drive into another master's transfer, or start again unseen. Losses in each of the three phases check that the recorded phase code is correct. A long pseudo-random stretch of line activity, with START and STOP in the same cycles as mismatches, is checked against a behavioural reference model on every clock.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_ADDR = 2'b00,
        PH_HS   = 2'b01,
        PH_DATA = 2'b10,
        PH_NONE = 2'b11
    } phase_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    typedef enum logic [1:0] {
        ARB_WATCH     = 2'b00,
        ARB_LOST_BUSY = 2'b01,
        ARB_LOST_DONE = 2'b10
    } arb_state_e;
endpackage

// File: rtl/i2c_line_edges.sv
module i2c_line_edges #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic start_det,
    output logic stop_det
);
    logic sda_q;
    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_q <= IDLE_LEVEL;
            scl_q <= IDLE_LEVEL;
        end else begin
            sda_q <= sda_in;
            scl_q <= scl_in;
        end
    end

    // SDA edge with SCL held high across both samples
    always_comb begin
        start_det = scl_q && scl_in && sda_q && !sda_in;
        stop_det  = scl_q && scl_in && !sda_q && sda_in;
    end
endmodule

// File: rtl/i2c_bus_tracker.sv
module i2c_bus_tracker
    import i2c_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_det,
    input  logic stop_det,
    output logic bus_busy
);
    bus_state_e state_q;
    bus_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (start_det) state_d = BUS_BUSY;
            BUS_BUSY: if (stop_det && !start_det) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_busy = (state_q == BUS_BUSY);
    end

    p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> bus_busy);
    p_idle_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !bus_busy);
endmodule

// File: rtl/i2c_arb_tracker.sv
module i2c_arb_tracker
    import i2c_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_in,
    input  logic               scl_in,
    input  logic               sda_intent,
    input  logic               drive_en,
    input  logic               ack_slot,
    input  logic [PHASE_W-1:0] phase,
    input  logic               lost_clr,
    input  logic               stop_det,
    output logic               arb_lost,
    output logic               sda_off,
    output logic               scl_off,
    output logic [PHASE_W-1:0] lost_phase
);
    arb_state_e         state_q;
    arb_state_e         state_d;
    logic [PHASE_W-1:0] lphase_q;
    logic [PHASE_W-1:0] lphase_d;
    logic               contest;
    logic               mismatch;

    always_comb begin
        contest  = drive_en && !ack_slot && (phase != PH_NONE);
        mismatch = contest && scl_in && sda_intent && !sda_in;
    end

    always_comb begin
        state_d  = state_q;
        lphase_d = lphase_q;
        unique case (state_q)
            ARB_WATCH: begin
                if (mismatch) begin
                    state_d  = ARB_LOST_BUSY;
                    lphase_d = phase;
                end
            end
            ARB_LOST_BUSY: begin
                if (stop_det) state_d = ARB_LOST_DONE;
            end
            ARB_LOST_DONE: begin
                if (lost_clr) begin
                    state_d  = ARB_WATCH;
                    lphase_d = '0;
                end
            end
            default: begin
                state_d  = ARB_WATCH;
                lphase_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ARB_WATCH;
            lphase_q <= '0;
        end else begin
            state_q  <= state_d;
            lphase_q <= lphase_d;
        end
    end

    always_comb begin
        arb_lost   = (state_q != ARB_WATCH);
        sda_off    = (state_q == ARB_LOST_BUSY);
        scl_off    = (state_q == ARB_LOST_BUSY);
        lost_phase = lphase_q;
    end

    p_lose_on_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_lost && drive_en && sda_intent && scl_in && !sda_in && !ack_slot
         && phase != PH_NONE) |=> (arb_lost && sda_off && scl_off));
    p_no_loss_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_lost && !scl_in) |=> !arb_lost);
    p_ack_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_lost && ack_slot) |=> !arb_lost);
    p_phase_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !lost_clr) |=> $stable(lost_phase));
    p_release_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_off && !stop_det) |=> (sda_off && scl_off));
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !lost_clr) |=> arb_lost);
endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
    import i2c_arb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_in,
    input  logic               scl_in,
    input  logic               sda_intent,
    input  logic               drive_en,
    input  logic               ack_slot,
    input  logic [PHASE_W-1:0] phase,
    input  logic               lost_clr,
    output logic               bus_busy,
    output logic               arb_lost,
    output logic               sda_off,
    output logic               scl_off,
    output logic               start_ok,
    output logic [PHASE_W-1:0] lost_phase
);
    logic start_det;
    logic stop_det;

    i2c_line_edges #(.IDLE_LEVEL(1'b1)) u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_in    (sda_in),
        .scl_in    (scl_in),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bus_tracker u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .bus_busy  (bus_busy)
    );

    i2c_arb_tracker u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_in     (sda_in),
        .scl_in     (scl_in),
        .sda_intent (sda_intent),
        .drive_en   (drive_en),
        .ack_slot   (ack_slot),
        .phase      (phase),
        .lost_clr   (lost_clr),
        .stop_det   (stop_det),
        .arb_lost   (arb_lost),
        .sda_off    (sda_off),
        .scl_off    (scl_off),
        .lost_phase (lost_phase)
    );

    always_comb begin
        start_ok = !bus_busy && !arb_lost;
    end

    p_no_start_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_ok);
endmodule

// File: tb/i2c_arb_monitor_test.sv
module i2c_arb_monitor_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda_in = 1'b1, scl_in = 1'b1, sda_intent = 1'b1, drive_en = 1'b0;
    logic       ack_slot = 1'b0, lost_clr = 1'b0;
    logic [1:0] phase = 2'b11;
    logic       bus_busy, arb_lost, sda_off, scl_off, start_ok;
    logic [1:0] lost_phase;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural reference state
    int m_busy = 0, m_lost = 0, m_rel = 0, m_ph = 0, m_psda = 1, m_pscl = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_arb_monitor uut (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .sda_intent(sda_intent), .drive_en(drive_en), .ack_slot(ack_slot),
        .phase(phase), .lost_clr(lost_clr), .bus_busy(bus_busy),
        .arb_lost(arb_lost), .sda_off(sda_off), .scl_off(scl_off),
        .start_ok(start_ok), .lost_phase(lost_phase)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_lost = 0; m_rel = 0; m_ph = 0; m_psda = 1; m_pscl = 1;
        end else begin
            bit st, sp, mm;
            st = m_pscl && scl_in && m_psda && !sda_in;
            sp = m_pscl && scl_in && !m_psda && sda_in;
            mm = drive_en && sda_intent && scl_in && !sda_in && !ack_slot && phase != 2'b11;
            if (st) m_busy = 1;
            else if (sp) m_busy = 0;
            if (m_lost == 0) begin
                if (mm) begin m_lost = 1; m_rel = 1; m_ph = int'(phase); end
            end else if (m_rel == 1) begin
                if (sp) m_rel = 0;
            end else if (lost_clr) begin
                m_lost = 0; m_ph = 0;
            end
            m_psda = sda_in;
            m_pscl = scl_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1/R2 bus_busy vs model", int'(bus_busy), m_busy);
            chk("R3/R8 arb_lost vs model", int'(arb_lost), m_lost);
            chk("R7 sda_off vs model", int'(sda_off), m_rel);
            chk("R7 scl_off vs model", int'(scl_off), m_rel);
            chk("R9 start_ok vs model", int'(start_ok), int'(m_busy == 0 && m_lost == 0));
            chk("R6 lost_phase vs model", int'(lost_phase), m_ph);
        end
    end

    task automatic step(input logic sda, input logic scl, input logic drv,
                        input logic intent, input logic ack, input logic [1:0] ph,
                        input logic clr);
        sda_in = sda; scl_in = scl; drive_en = drv; sda_intent = intent;
        ack_slot = ack; phase = ph; lost_clr = clr;
        @(negedge clk);
    endtask

    task automatic do_start();
        step(1, 1, 0, 1, 0, 2'b11, 0);
        step(0, 1, 0, 1, 0, 2'b11, 0);
        step(0, 0, 0, 1, 0, 2'b11, 0);
    endtask

    task automatic do_stop();
        step(0, 0, 0, 1, 0, 2'b11, 0);
        step(0, 1, 0, 1, 0, 2'b11, 0);
        step(1, 1, 0, 1, 0, 2'b11, 0);
    endtask

    task automatic lose_in(input logic [1:0] ph, input string tag);
        do_start();
        step(0, 0, 1, 1, 0, ph, 0);
        step(0, 1, 1, 1, 0, ph, 0);
        chk({tag, " arb_lost after mismatch"}, int'(arb_lost), 1);
        chk({tag, " lost_phase recorded"}, int'(lost_phase), int'(ph));
        step(0, 0, 0, 1, 0, 2'b11, 0);
        do_stop();
        step(1, 1, 0, 1, 0, 2'b11, 1);
        chk({tag, " cleared after stop"}, int'(arb_lost), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset bus_busy", int'(bus_busy), 0);
        chk("R10 reset arb_lost", int'(arb_lost), 0);
        chk("R10 reset sda_off", int'(sda_off), 0);
        chk("R10 reset scl_off", int'(scl_off), 0);
        chk("R10 reset start_ok", int'(start_ok), 1);
        chk("R10 reset lost_phase", int'(lost_phase), 0);

        do_start();
        chk("R1 busy after start", int'(bus_busy), 1);
        chk("R9 start_ok low while busy", int'(start_ok), 0);

        // non-qualifying mismatches
        step(0, 0, 1, 1, 0, 2'b00, 0);
        chk("R4 scl low no loss", int'(arb_lost), 0);
        step(0, 1, 1, 0, 0, 2'b00, 0);
        chk("R4 intent 0 no loss", int'(arb_lost), 0);
        step(0, 1, 0, 1, 0, 2'b00, 0);
        chk("R4 not driving no loss", int'(arb_lost), 0);
        step(0, 1, 1, 1, 1, 2'b10, 0);
        chk("R5 ack slot ignored", int'(arb_lost), 0);
        chk("R5 ack slot no release", int'(sda_off), 0);
        step(0, 1, 1, 1, 0, 2'b11, 0);
        chk("R5 no-phase ignored", int'(arb_lost), 0);
        step(1, 1, 1, 1, 0, 2'b00, 0);
        step(1, 0, 1, 1, 0, 2'b00, 0);
        chk("R3 matching bit no loss", int'(arb_lost), 0);

        do_stop();
        chk("R2 idle after stop", int'(bus_busy), 0);
        chk("R9 start_ok after stop", int'(start_ok), 1);

        // address-phase loss with clear attempts
        do_start();
        step(0, 0, 1, 1, 0, 2'b00, 0);
        step(0, 1, 1, 1, 0, 2'b00, 0);
        chk("R3 arb_lost", int'(arb_lost), 1);
        chk("R3 sda_off", int'(sda_off), 1);
        chk("R3 scl_off", int'(scl_off), 1);
        chk("R6 address phase code", int'(lost_phase), 0);
        step(0, 0, 0, 1, 0, 2'b11, 1);
        chk("R8 clear ignored while released", int'(arb_lost), 1);
        chk("R7 release held before stop", int'(sda_off), 1);
        step(0, 1, 0, 1, 0, 2'b11, 0);
        step(1, 1, 0, 1, 0, 2'b11, 0);
        chk("R7 sda_off drops after stop", int'(sda_off), 0);
        chk("R7 scl_off drops after stop", int'(scl_off), 0);
        chk("R7 arb_lost kept after stop", int'(arb_lost), 1);
        chk("R9 start_ok low while lost", int'(start_ok), 0);
        step(1, 1, 0, 1, 0, 2'b11, 0);
        chk("R8 sticky without clear", int'(arb_lost), 1);
        step(1, 1, 0, 1, 0, 2'b11, 1);
        chk("R8 cleared", int'(arb_lost), 0);
        chk("R8 phase cleared", int'(lost_phase), 0);
        chk("R9 start_ok after clear", int'(start_ok), 1);

        lose_in(2'b01, "R6 hs-code");
        lose_in(2'b10, "R6 data");

        // pseudo-random line activity checked against the model
        begin
            int unsigned lfsr = 32'h1234_5678;
            for (int i = 0; i < 4000; i++) begin
                lfsr = lfsr * 32'd1664525 + 32'd1013904223;
                step(lfsr[20], lfsr[21] | lfsr[22], lfsr[23], lfsr[24],
                     lfsr[25] & lfsr[26], lfsr[28:27], lfsr[29] & lfsr[30] & lfsr[31]);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule